// File: doc/BRIEF.md
# PWM Sample Word Decoder

This block sits between the unit that fetches duty samples and the pulse generator. When the pulse generator asks for a new step, the decoder takes in one, two or four 16-bit sample words through a valid/ready handshake. It then writes them to four channel compare words, and in one mode to the counter top value. A two-bit load mode picks how the words are spread over the outputs. The mode is captured at the moment the step is requested.

Every sample word is passed through unchanged. Bit 15 carries the output polarity and bits 14:0 carry the compare value. All outputs change together, once the last word of the step has been accepted. A flag on the incoming word marks the end of the sequence. If that flag arrives before the step is complete, the partial step is discarded and an error strobe is raised instead.

Top module: `pwm_seq_decoder`

## Requirements
- R1: While reset is held and after it is released, every compare word, the top value, top_valid, word_ready, step_done and step_err are all zero.
- R2: Mode 0 (common) takes one word per step and writes it to all four channels.
- R3: Mode 1 (paired) takes two words per step. The first word goes to channels 0 and 1, and the second to channels 2 and 3.
- R4: Mode 2 (separate) takes four words per step. Words one to four go to channels 0 to 3 in that order.
- R5: Mode 3 (waveform) takes four words per step. Words one to three go to channels 0 to 2, channel 3 is set to the idle word 0x0000, the fourth word becomes top_value, and top_valid goes to 1. A completed step in any other mode sets top_valid to 0 and leaves top_value as it was.
- R6: All 16 bits of a word, including polarity bit 15, reach the outputs unaltered.
- R7: word_ready rises in the cycle after a load_req seen while idle. It falls in the cycle after the step's last word is accepted. A load_req that arrives while a step is being collected has no effect, and a word offered while idle is not consumed.
- R8: The outputs change only in the cycle in which step_done is high. step_done lasts one cycle and comes one cycle after the handshake that completes the step.
- R9: A change on load_mode during a step has no effect on that step. The mode sampled together with load_req decides the word count and the mapping.
- R10: When a word carrying word_last is accepted before the step is complete, step_err pulses for one cycle, the outputs keep their values and the decoder returns to idle. When word_last comes on the step's final word, the step completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_mode | input | 2 | 0 common, 1 paired, 2 separate, 3 waveform |
| load_req | input | 1 | Pulse generator request for the next step |
| word_valid | input | 1 | Sample word offered |
| word_ready | output | 1 | Decoder is collecting a step |
| word_data | input | 16 | Sample word: polarity bit 15, value bits 14:0 |
| word_last | input | 1 | Offered word is the final word of the sequence |
| chan_cmp | output | 64 | Channel compare words, channel n in bits 16n+15:16n |
| top_value | output | 16 | Counter top value taken from waveform steps |
| top_valid | output | 1 | Most recent step was a waveform step |
| step_done | output | 1 | One-cycle strobe: a step was committed |
| step_err | output | 1 | One-cycle strobe: a partial step was dropped |

## Verification
The hardest situations to reach from the ports are stimuli that arrive in the middle of a step. The bench has to switch load_mode, repeat load_req and put bubbles on word_valid while the decoder is partway through collecting the words of a step. The end-of-sequence flag also has to land on every possible word position of every mode. A randomized phase does this many times, keying each disturbance to the bench's own model of the step in progress. The behavioural model predicts every output on every clock, so any early or partial update of a compare word shows up in the very cycle it happens.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;
   typedef enum logic [1:0] {
      LD_COMMON   = 2'd0,
      LD_PAIRED   = 2'd1,
      LD_SEPARATE = 2'd2,
      LD_WAVE     = 2'd3
   } ld_mode_e;

   // number of sample words consumed by one step in each mode
   function automatic logic [2:0] words_per_step(input ld_mode_e m);
      case (m)
         LD_COMMON: return 3'd1;
         LD_PAIRED: return 3'd2;
         default:   return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/seq_collector.sv
module seq_collector
   import pwm_dec_pkg::*;
#(
   parameter int W    = 16,
   parameter int MAXW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_in,
   input  logic            load_req,
   input  logic            word_valid,
   input  logic [W-1:0]    word_data,
   input  logic            word_last,
   output logic            word_ready,
   output logic            commit,
   output logic            abort,
   output ld_mode_e        mode_q,
   output logic [MAXW*W-1:0] words
);
   localparam int CW = $clog2(MAXW);

   if (MAXW != 4) begin : g_bad_depth
      $error("seq_collector: MAXW must be 4");
   end

   logic            busy_q;
   logic [CW-1:0]   cnt_q;
   logic [CW:0]     need;
   logic            hs;
   logic [W-1:0]    stage_q [MAXW];

   assign need       = words_per_step(mode_q);
   assign word_ready = busy_q;
   assign hs         = busy_q & word_valid;
   assign commit     = hs && ({1'b0, cnt_q} == need - 1'b1);
   assign abort      = hs && word_last && !commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         mode_q <= LD_COMMON;
      end else if (!busy_q) begin
         if (load_req) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            mode_q <= ld_mode_e'(mode_in);
         end
      end else if (hs) begin
         if (commit || abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < MAXW; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[i] <= '0;
         else if (hs && (cnt_q == CW'(i)))
            stage_q[i] <= word_data;
      end
      // the word arriving now completes the set in the same cycle
      assign words[i*W +: W] = (cnt_q == CW'(i)) ? word_data : stage_q[i];
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ({1'b0, cnt_q} < need)) else $error("cnt overflow"); // R8
   AST_READY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_ready) |-> $past(load_req)) else $error("ready without request"); // R7
endmodule

// File: rtl/lane_spreader.sv
module lane_spreader
   import pwm_dec_pkg::*;
#(
   parameter int W    = 16,
   parameter int NCH  = 4,
   parameter int MAXW = 4
) (
   input  ld_mode_e          mode,
   input  logic [MAXW*W-1:0] words,
   output logic [NCH*W-1:0]  cmp,
   output logic [W-1:0]      top,
   output logic              top_vld
);
   localparam logic [W-1:0] IDLE_WORD = '0;

   if (NCH != 4) begin : g_bad_nch
      $error("lane_spreader: NCH must be 4");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int PAIR = c / 2;
      localparam logic LAST_CH = (c == NCH - 1);
      assign cmp[c*W +: W] =
           (mode == LD_COMMON) ? words[0 +: W]
         : (mode == LD_PAIRED) ? words[PAIR*W +: W]
         : (mode == LD_SEPARATE) ? words[c*W +: W]
         : (LAST_CH ? IDLE_WORD : words[c*W +: W]);
   end

   assign top     = words[(MAXW-1)*W +: W];
   assign top_vld = (mode == LD_WAVE);
endmodule

// File: rtl/pwm_seq_decoder.sv
module pwm_seq_decoder
   import pwm_dec_pkg::*;
#(
   parameter int W    = 16,
   parameter int NCH  = 4,
   parameter int MAXW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       load_mode,
   input  logic             load_req,
   input  logic             word_valid,
   output logic             word_ready,
   input  logic [W-1:0]     word_data,
   input  logic             word_last,
   output logic [NCH*W-1:0] chan_cmp,
   output logic [W-1:0]     top_value,
   output logic             top_valid,
   output logic             step_done,
   output logic             step_err
);
   if (W < 2) begin : g_bad_w
      $error("pwm_seq_decoder: W too small");
   end

   logic              commit, abort, spr_tv;
   ld_mode_e          mode_q;
   logic [MAXW*W-1:0] words;
   logic [NCH*W-1:0]  spr_cmp;
   logic [W-1:0]      spr_top;

   seq_collector #(.W(W), .MAXW(MAXW)) u_col (
      .clk(clk), .rst_n(rst_n), .mode_in(load_mode), .load_req(load_req),
      .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
      .word_ready(word_ready), .commit(commit), .abort(abort),
      .mode_q(mode_q), .words(words));

   lane_spreader #(.W(W), .NCH(NCH), .MAXW(MAXW)) u_spr (
      .mode(mode_q), .words(words), .cmp(spr_cmp), .top(spr_top),
      .top_vld(spr_tv));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_cmp  <= '0;
         top_value <= '0;
         top_valid <= 1'b0;
         step_done <= 1'b0;
         step_err  <= 1'b0;
      end else begin
         step_done <= commit;
         step_err  <= abort;
         if (commit) begin
            chan_cmp  <= spr_cmp;
            top_valid <= spr_tv;
            if (spr_tv) top_value <= spr_top;
         end
      end
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !step_done |-> ($stable(chan_cmp) && $stable(top_value))) else $error("early update"); // R8
   AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> $past(word_valid && word_ready)) else $error("done without word"); // R8
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_done && step_err)) else $error("done and err together"); // R10
   AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      step_err |-> ($stable(chan_cmp) && $stable(top_valid))) else $error("err changed outputs"); // R10
   AST_WAVE_CH3_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_done && top_valid) |-> (chan_cmp[(NCH-1)*W +: W] == '0)) else $error("ch3 not idle"); // R5
endmodule

// File: tb/pwm_seq_decoder_tb.sv
module pwm_seq_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  load_mode = 2'd0;
   logic        load_req = 1'b0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [15:0] word_data = 16'h0;
   logic        word_last = 1'b0;
   logic [63:0] chan_cmp;
   logic [15:0] top_value;
   logic        top_valid, step_done, step_err;

   always #4 clk = ~clk;

   pwm_seq_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .load_req(load_req),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .word_last(word_last), .chan_cmp(chan_cmp), .top_value(top_value),
      .top_valid(top_valid), .step_done(step_done), .step_err(step_err));

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   bit armed = 0;
   string scen = "R2";

   // behavioural reference
   bit          m_busy = 0;
   int          m_mode = 0;
   logic [15:0] q[$];
   logic [15:0] m_ch[4] = '{default: 16'h0};
   logic [15:0] m_top = 0;
   bit          m_tv = 0, m_done = 0, m_err = 0;

   function automatic int wps(int m);
      return (m == 0) ? 1 : (m == 1) ? 2 : 4;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; q.delete(); m_ch = '{default: 16'h0};
         m_top = 0; m_tv = 0; m_done = 0; m_err = 0;
      end else begin
         m_done = 0; m_err = 0;
         if (!m_busy) begin
            if (load_req) begin m_busy = 1; m_mode = load_mode; q.delete(); end
         end else if (word_valid) begin
            q.push_back(word_data);
            if (q.size() == wps(m_mode)) begin
               m_busy = 0; m_done = 1;
               case (m_mode)
                  0: for (int i = 0; i < 4; i++) m_ch[i] = q[0];
                  1: begin m_ch[0] = q[0]; m_ch[1] = q[0]; m_ch[2] = q[1]; m_ch[3] = q[1]; end
                  2: for (int i = 0; i < 4; i++) m_ch[i] = q[i];
                  default: begin
                     for (int i = 0; i < 3; i++) m_ch[i] = q[i];
                     m_ch[3] = 16'h0; m_top = q[3];
                  end
               endcase
               m_tv = (m_mode == 3);
            end else if (word_last) begin
               m_busy = 0; m_err = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         vectors++;
         if (word_ready !== m_busy) begin
            fails++; $display("FAIL R7 ready actual=%0b expected=%0b", word_ready, m_busy);
         end
         if (step_done !== m_done) begin
            fails++; $display("FAIL R8 done actual=%0b expected=%0b", step_done, m_done);
         end
         if (step_err !== m_err) begin
            fails++; $display("FAIL R10 err actual=%0b expected=%0b", step_err, m_err);
         end
         if (chan_cmp !== {m_ch[3], m_ch[2], m_ch[1], m_ch[0]}) begin
            fails++; $display("FAIL %s cmp actual=%0h expected=%0h", scen, chan_cmp,
                              {m_ch[3], m_ch[2], m_ch[1], m_ch[0]});
         end
         if (top_value !== m_top || top_valid !== m_tv) begin
            fails++; $display("FAIL R5 top actual=%0h/%0b expected=%0h/%0b",
                              top_value, top_valid, m_top, m_tv);
         end
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         summary();
      end
   end

   // returns at the negedge right after the last word's accepting edge
   task automatic run_step(input logic [1:0] m, input logic [63:0] ws, input int n,
                           input bit mark_last, input bit noise);
      bit acc;
      @(negedge clk); load_mode = m; load_req = 1;
      @(negedge clk); load_req = 0;
      if (noise) load_mode = ~m;                            // R9 disturbance
      for (int i = 0; i < n; i++) begin
         if (noise) begin word_valid = 0; @(negedge clk); load_req = 1; end // R7 stray request
         word_valid = 1; word_data = ws[i*16 +: 16];
         word_last = mark_last && (i == n - 1);
         forever begin acc = word_ready; @(negedge clk); if (acc) break; end
         word_valid = 0; word_last = 0; load_req = 0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {chan_cmp, top_value[0], top_valid, word_ready, step_done, step_err},
          {64'h0, 5'b0});
      rst_n = 1; armed = 1;
      @(negedge clk);
      chk("R1", {top_value, 48'h0}, 64'h0);

      scen = "R2"; run_step(2'd0, 64'h1234, 1, 0, 0);
      chk("R2", chan_cmp, 64'h1234_1234_1234_1234);
      scen = "R6"; run_step(2'd0, 64'h8005, 1, 0, 0);
      chk("R6", chan_cmp, 64'h8005_8005_8005_8005);
      scen = "R3"; run_step(2'd1, 64'h8022_0011, 2, 0, 0);
      chk("R3", chan_cmp, 64'h8022_8022_0011_0011);
      scen = "R4"; run_step(2'd2, 64'h4444_B333_2222_1111, 4, 0, 1);
      chk("R4", chan_cmp, 64'h4444_B333_2222_1111);
      scen = "R5"; run_step(2'd3, 64'h03E8_F003_0002_8001, 4, 0, 0);
      chk("R5", {chan_cmp[47:0], top_value}, {48'hF003_0002_8001, 16'h03E8});
      chk("R5", {48'h0, chan_cmp[63:48]}, 64'h0);
      chk("R5", {63'h0, top_valid}, 64'h1);
      run_step(2'd0, 64'h0777, 1, 0, 0);
      chk("R5", {47'h0, top_valid, top_value}, {47'h0, 1'b0, 16'h03E8});

      // words offered while idle are not consumed
      scen = "R7"; @(negedge clk); word_valid = 1; word_data = 16'hDEAD;
      repeat (3) begin @(negedge clk); chk("R7", {63'h0, word_ready}, 64'h0); end
      word_valid = 0;

      scen = "R9"; run_step(2'd1, 64'h0B0B_0A0A, 2, 0, 1);
      chk("R9", chan_cmp, 64'h0B0B_0B0B_0A0A_0A0A);

      scen = "R10"; run_step(2'd2, 64'h0000_0000_5555_6666, 2, 1, 0);
      chk("R10", {63'h0, step_err}, 64'h1);
      chk("R10", chan_cmp, 64'h0B0B_0B0B_0A0A_0A0A);
      run_step(2'd1, 64'h0C0C_0D0D, 2, 1, 0);
      chk("R10", {62'h0, step_done, step_err}, 64'h2);

      scen = "R8";
      for (int s = 0; s < 300; s++) begin
         int m, n;
         bit early;
         m = $urandom_range(0, 3);
         early = ($urandom_range(0, 4) == 0) && (wps(m) > 1);
         n = early ? $urandom_range(1, wps(m) - 1) : wps(m);
         run_step(m[1:0], {$urandom, $urandom}, n, early || ($urandom_range(0, 1) == 1),
                  $urandom_range(0, 2) == 0);
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      summary();
   end
endmodule